// File: doc/BRIEF.md
# Bang-Bang Phase Detector Vote Encoder

This block sits behind a half-rate slicer and its deserializer in a clock and data recovery loop. Each accepted word carries a group of data samples, taken at the centres of consecutive bits, and an equal group of edge samples, each taken between two neighbouring data samples. For every lane the block decides whether the recovered clock sampled the edge too early or too late. It does this by comparing the edge sample against the data bit on each side of it. It then sums the lane decisions into a single signed vote for the loop filter.

The edge sample of the last lane sits between the last data bit of a word and the first data bit of the word that follows. The block therefore holds each word until the next one arrives and evaluates it then. Each vote comes one word late. A lane counts only when its two neighbouring data bits differ, because an edge sample means nothing without a transition. The net count is sent out in sign-magnitude form with the sign in the top bit.

Top module: `bbpd_vote_enc`

## Requirements
- R1: Bit i of `dataWord` and of `phaseWord` belongs to lane i+1, and bit 0 is the oldest sample. A lane with a data transition gives an early vote (+1) when its edge sample equals the data bit before it.
- R2: A lane with a data transition gives a late vote (-1) when its edge sample equals the data bit after it. For the last lane, that following bit is bit 0 of the next accepted word.
- R3: A lane whose two neighbouring data bits are equal adds nothing, whatever its edge sample. A run of equal bits across a word gives a vote of zero.
- R4: `vote` is sign-magnitude: bit 3 is the sign (1 = negative) and bits 2:0 are the magnitude of (early count - late count), range -4..+4. Examples: -1 = 1001, -3 = 1011, -4 = 1100, +4 = 0100, 0 = 0000. The code 1000 is never produced.
- R5: `voteValid` is high for exactly the one cycle after an accepted word, and only when an earlier word has been accepted since reset. The new `vote` appears in that same cycle and covers the earlier word. The first word after reset produces no vote.
- R6: In cycles where `wordValid` is low, `vote` keeps its value and `voteValid` stays low.
- R7: A synchronous reset clears the held word, sets `vote` to 0000 and drives `voteValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| wordValid | input | 1 | A new sample word is present this cycle |
| dataWord | input | LANES | Data samples, bit 0 oldest |
| phaseWord | input | LANES | Edge samples, bit i between data bits i and i+1 |
| vote | output | CNT_W+1 | Sign-magnitude net vote |
| voteValid | output | 1 | One-cycle strobe marking a new vote |

## Verification
The bench builds the block with its default of four lanes. This makes the full vote range from -4 to +4 reachable, along with every sign-magnitude code from the examples. Directed word pairs drive the extremes, the single-lane late case and a transition-free run. These pairs also pin down that the last lane borrows its following bit from the next word. Random words with randomly gapped valid strobes exercise the one-word delay, the hold behaviour in idle cycles, and a reset in mid-stream.

// File: rtl/bbpd_vote_pkg.sv
package bbpd_vote_pkg;
  // strobes passed from the control to the datapath
  typedef struct packed {
    logic capture;  // latch the incoming word as the held word
    logic emit;     // evaluate the held word and publish a vote
  } voteCtrl_t;
endpackage

// File: rtl/bbpd_vote_ctrl.sv
module bbpd_vote_ctrl
  import bbpd_vote_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wordValid,
  output voteCtrl_t ctrl
);
  logic heldValid;

  always_ff @(posedge clk) begin
    if (rst)            heldValid <= 1'b0;
    else if (wordValid) heldValid <= 1'b1;
  end

  always_comb begin
    ctrl.capture = wordValid;
    ctrl.emit    = wordValid & heldValid;
  end
endmodule

// File: rtl/bbpd_lane.sv
module bbpd_lane (
  input  logic dPrev,
  input  logic pMid,
  input  logic dNext,
  output logic early,
  output logic late
);
  logic edgeSeen;

  always_comb begin
    edgeSeen = dPrev ^ dNext;
    early    = edgeSeen & ~(dPrev ^ pMid);
    late     = edgeSeen & ~(pMid ^ dNext);
  end
endmodule

// File: rtl/bbpd_vote_dp.sv
module bbpd_vote_dp
  import bbpd_vote_pkg::*;
#(
  parameter int LANES = 4,
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  voteCtrl_t        ctrl,
  input  logic [LANES-1:0] dataWord,
  input  logic [LANES-1:0] phaseWord,
  output logic [CNT_W:0]   vote,
  output logic             voteValid
);
  logic [LANES-1:0] heldData;
  logic [LANES-1:0] heldPhase;
  logic [LANES:0]   dataExt;
  logic [LANES-1:0] earlyBits;
  logic [LANES-1:0] lateBits;
  logic [CNT_W-1:0] earlyCnt;
  logic [CNT_W-1:0] lateCnt;
  logic [CNT_W:0]   voteNext;

  always_comb dataExt = {dataWord[0], heldData};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bbpd_lane u_lane (
      .dPrev (dataExt[g]),
      .pMid  (heldPhase[g]),
      .dNext (dataExt[g+1]),
      .early (earlyBits[g]),
      .late  (lateBits[g])
    );
  end

  always_comb begin
    earlyCnt = '0;
    lateCnt  = '0;
    for (int i = 0; i < LANES; i++) begin
      earlyCnt = earlyCnt + {{(CNT_W-1){1'b0}}, earlyBits[i]};
      lateCnt  = lateCnt  + {{(CNT_W-1){1'b0}}, lateBits[i]};
    end
    if (earlyCnt >= lateCnt) voteNext = {1'b0, earlyCnt - lateCnt};
    else                     voteNext = {1'b1, lateCnt - earlyCnt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      heldData  <= '0;
      heldPhase <= '0;
      vote      <= '0;
      voteValid <= 1'b0;
    end else begin
      voteValid <= ctrl.emit;
      if (ctrl.emit)    vote <= voteNext;
      if (ctrl.capture) begin
        heldData  <= dataWord;
        heldPhase <= phaseWord;
      end
    end
  end
endmodule

// File: rtl/bbpd_vote_enc.sv
module bbpd_vote_enc
  import bbpd_vote_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wordValid,
  input  logic [LANES-1:0] dataWord,
  input  logic [LANES-1:0] phaseWord,
  output logic [CNT_W:0]   vote,
  output logic             voteValid
);
  voteCtrl_t ctrl;

  bbpd_vote_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wordValid (wordValid),
    .ctrl      (ctrl)
  );

  bbpd_vote_dp #(.LANES(LANES), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .dataWord  (dataWord),
    .phaseWord (phaseWord),
    .vote      (vote),
    .voteValid (voteValid)
  );
endmodule

// File: rtl/bbpd_vote_chk.sv
module bbpd_vote_chk #(
  parameter int LANES = 4,
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           wordValid,
  input logic [CNT_W:0] vote,
  input logic           voteValid
);
  // R5: a vote strobe always follows an accepted word
  p_valid_needs_word_r5: assert property (@(posedge clk) disable iff (rst)
    voteValid |-> $past(wordValid));

  // R4: negative zero is never emitted
  p_no_neg_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !(vote[CNT_W] && vote[CNT_W-1:0] == '0));

  // R4: magnitude stays within the lane count
  p_mag_bound_r4: assert property (@(posedge clk) disable iff (rst)
    int'(vote[CNT_W-1:0]) <= LANES);

  // R6: an idle cycle leaves the vote untouched and the strobe low
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wordValid |=> ($stable(vote) && !voteValid));

  // R7: reset clears the outputs
  p_reset_r7: assert property (@(posedge clk)
    rst |=> (vote == '0 && !voteValid));
endmodule

bind bbpd_vote_enc bbpd_vote_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wordValid (wordValid),
  .vote      (vote),
  .voteValid (voteValid)
);

// File: tb/sim_bbpd_vote_enc.sv
`timescale 1ns/1ps
module sim_bbpd_vote_enc;
  localparam int LANES = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wordValid = 1'b0;
  logic [3:0] dataWord = '0;
  logic [3:0] phaseWord = '0;
  logic [3:0] vote;
  logic       voteValid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  logic [3:0] mPrevD, mPrevP;
  bit         mHave = 0;
  logic [3:0] expVote = '0;
  bit         expValid = 0;
  bit         lastWv = 0;

  always #4 clk = ~clk;

  bbpd_vote_enc #(.LANES(LANES)) u0 (
    .clk(clk), .rst(rst), .wordValid(wordValid),
    .dataWord(dataWord), .phaseWord(phaseWord),
    .vote(vote), .voteValid(voteValid)
  );

  function automatic logic [3:0] refVote(logic [3:0] d, logic [3:0] p, logic nxt);
    int net = 0;
    logic [4:0] ext = {nxt, d};
    for (int i = 0; i < 4; i++) begin
      if (ext[i] != ext[i+1]) begin
        if (p[i] == ext[i]) net++;
        else                net--;
      end
    end
    if (net < 0) return {1'b1, 3'(-net)};
    return {1'b0, 3'(net)};
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // compare outputs at the falling edge, then drive the next cycle
  task automatic step(bit r, bit wv, logic [3:0] d, logic [3:0] p);
    @(negedge clk);
    check(lastWv ? "R1" : "R6", vote, expVote);
    check("R5", {3'b0, voteValid}, {3'b0, expValid});
    rst = r; wordValid = wv; dataWord = d; phaseWord = p;
    if (r) begin
      mHave = 0; expVote = '0; expValid = 0;
    end else if (wv) begin
      expValid = mHave;
      if (mHave) expVote = refVote(mPrevD, mPrevP, d[0]);
      mPrevD = d; mPrevP = p; mHave = 1;
    end else begin
      expValid = 0;
    end
    lastWv = wv && !r;
  endtask

  // evaluate word a completed by b, then check the published code
  task automatic pair(string req, logic [3:0] ad, logic [3:0] ap,
                      logic [3:0] bd, logic [3:0] exp);
    step(0, 1, ad, ap);
    step(0, 1, bd, 4'b0000);
    step(0, 0, 4'b0000, 4'b0000);
    check(req, vote, exp);
  endtask

  initial begin
    repeat (3) step(1, 0, 4'b0000, 4'b0000);
    step(0, 0, 4'b0000, 4'b0000);
    check("R7", vote, 4'b0000);
    check("R7", {3'b0, voteValid}, 4'b0000);

    // first word after reset yields no strobe (R5)
    step(0, 1, 4'b1010, 4'b1010);
    step(0, 0, 4'b0000, 4'b0000);
    check("R5", {3'b0, voteValid}, 4'b0000);

    pair("R1", 4'b1010, 4'b1010, 4'b1010, 4'b0100); // all early: +4
    pair("R2", 4'b1010, 4'b0101, 4'b1010, 4'b1100); // all late: -4
    pair("R2", 4'b1110, 4'b0001, 4'b1111, 4'b1001); // one late: -1
    pair("R4", 4'b1010, 4'b0101, 4'b1111, 4'b1011); // three late: -3
    pair("R3", 4'b0000, 4'b0110, 4'b0000, 4'b0000); // run: 0
    pair("R2", 4'b1010, 4'b1010, 4'b1011, 4'b0011); // last lane loses edge: +3

    // reset mid-stream
    step(0, 1, 4'b0101, 4'b0011);
    step(1, 0, 4'b0000, 4'b0000);
    step(0, 0, 4'b0000, 4'b0000);
    check("R7", vote, 4'b0000);

    for (int n = 0; n < 3000; n++) begin
      step(0, ($urandom_range(0, 3) != 0), 4'($urandom), 4'($urandom));
    end
    step(0, 0, 4'b0000, 4'b0000);

    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule